// File: doc/BRIEF.md
# Deferred-Exception Poison Register File

This block is a general-purpose register file for a core that relies on compiler-scheduled speculation. Each register holds a 64-bit value and one poison bit. A speculative operation that meets a fault condition does not trap. It writes its result and marks the destination as poisoned. A speculative operation that uses a poisoned source passes the poison on to its own result. The fault is reported only when that value is consumed: either a non-speculative operation reads it, or an explicit check operation tests it.

The block has two combinational read ports and one write port. Each cycle the pipeline presents at most one operation. The operation carries a speculative flag, a fault flag, an immediate-handling flag for faults that must not be deferred (for example a page fault), and use enables for its sources. A trapping operation never writes. The block reports each exception one cycle after the operation, as a single-cycle pulse that carries a cause code and a register index.

Top module: `defer_poison_rf`

## Requirements
- R1: After reset every register reads data zero with poison clear, and exc_o is low.
- R2: Each read port returns the data and poison of the register it addresses, combinationally. Register 0 always reads data zero with poison clear, and writes to it are ignored.
- R3: An execute operation (op_check_i=0) with spec_i=0, we_i=1, no fault and no poisoned used source stores wdata_i into rd_i at the clock edge with poison cleared. This also clears any earlier poison on rd_i.
- R4: An execute operation with spec_i=1, fault_i=1 and fault_imm_i=0 stores wdata_i with poison set and raises no exception.
- R5: An execute operation with spec_i=1 and a used source (srcN_use_i=1) that is poisoned stores a poisoned result and raises no exception. A source with its use enable low has no effect.
- R6: An execute operation with spec_i=0 and a used poisoned source raises a deferred exception (cause 2'b01) with the index of the poisoned register, and does not write.
- R7: If both used sources are poisoned, the register on read port 1 (rs1_i) is reported.
- R8: A check operation (op_check_i=1) raises a deferred exception (cause 2'b01, index rs1_i) when rs1_i is poisoned, raises nothing otherwise, and never writes.
- R9: An execute operation with fault_i=1 and either spec_i=0 or fault_imm_i=1 raises an immediate exception (cause 2'b10, index rd_i) and does not write. A deferred exception takes priority over an immediate one.
- R10: exc_o is high for exactly the cycle after a trapping operation and low otherwise. exc_cause_o is 2'b00 whenever exc_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_check_i | input | 1 | 1 = check operation on rs1_i; 0 = execute operation |
| spec_i | input | 1 | Operation is speculative |
| fault_i | input | 1 | Operation met a fault condition |
| fault_imm_i | input | 1 | Handle this fault immediately even if the operation is speculative |
| src1_use_i | input | 1 | Operation consumes read port 1 |
| src2_use_i | input | 1 | Operation consumes read port 2 |
| rs1_i | input | 5 | Read port 1 index |
| rs2_i | input | 5 | Read port 2 index |
| rd_i | input | 5 | Destination index |
| we_i | input | 1 | Operation writes rd_i |
| wdata_i | input | 64 | Result data |
| rdata1_o | output | 64 | Read port 1 data |
| rpois1_o | output | 1 | Read port 1 poison |
| rdata2_o | output | 64 | Read port 2 data |
| rpois2_o | output | 1 | Read port 2 poison |
| exc_o | output | 1 | Exception pulse |
| exc_cause_o | output | 2 | 01 = deferred, 10 = immediate |
| exc_idx_o | output | 5 | Register index of the exception |

## Verification
Poison is created by a speculative fault and then carried through a two-step chain of speculative operations on port 1 and then port 2. This shows that propagation happens on each port and that neither step traps. A clean non-speculative overwrite comes before a later non-speculative use, and no exception may follow. A poisoned register left unused, with its use enable low, must also stay quiet. These two cases separate real consumption from mere presence of poison. Non-speculative consumption of single and double poisoned sources, check operations on clean and poisoned registers, and immediate faults with and without the speculative flag are each checked for cause, index, pulse width and suppressed write.

// File: rtl/defer_poison_pkg.sv
package defer_poison_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_DEFER = 2'b01,
    CAUSE_IMM   = 2'b10
  } exc_cause_e;
endpackage

// File: rtl/dp_regarray.sv
module dp_regarray #(
  parameter int NREGS = 32,
  parameter int XLEN  = 64,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   ra1_i,
  input  logic [AW-1:0]   ra2_i,
  output logic [XLEN-1:0] rd1_o,
  output logic            rp1_o,
  output logic [XLEN-1:0] rd2_o,
  output logic            rp2_o,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i,
  input  logic            wp_i
);
  logic [XLEN-1:0] data_arr [NREGS];
  logic            pois_arr [NREGS];

  assign data_arr[0] = '0;
  assign pois_arr[0] = 1'b0;

  for (genvar g = 1; g < NREGS; g++) begin : g_reg
    logic [XLEN-1:0] d_q;
    logic            p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= '0;
        p_q <= 1'b0;
      end else if (we_i && (wa_i == AW'(g))) begin
        d_q <= wd_i;
        p_q <= wp_i;
      end
    end
    assign data_arr[g] = d_q;
    assign pois_arr[g] = p_q;
  end

  assign rd1_o = data_arr[ra1_i];
  assign rp1_o = pois_arr[ra1_i];
  assign rd2_o = data_arr[ra2_i];
  assign rp2_o = pois_arr[ra2_i];

  assert_write_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0) |=> (data_arr[$past(wa_i)] == $past(wd_i)) && (pois_arr[$past(wa_i)] == $past(wp_i)));
  assert_zero_reg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_arr[0] == '0) && !pois_arr[0]);
endmodule

// File: rtl/dp_ctrl.sv
module dp_ctrl
  import defer_poison_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic          op_check_i,
  input  logic          spec_i,
  input  logic          fault_i,
  input  logic          fault_imm_i,
  input  logic          src1_use_i,
  input  logic          src2_use_i,
  input  logic [AW-1:0] rs1_i,
  input  logic [AW-1:0] rs2_i,
  input  logic [AW-1:0] rd_i,
  input  logic          we_i,
  input  logic          pois1_i,
  input  logic          pois2_i,
  output logic          wr_en_o,
  output logic          wr_pois_o,
  output logic          exc_d_o,
  output exc_cause_e    cause_d_o,
  output logic [AW-1:0] idx_d_o
);
  logic p1_used, p2_used, defer, imm;

  assign p1_used = src1_use_i & pois1_i;
  assign p2_used = src2_use_i & pois2_i;

  // check tests rs1 regardless of use enables
  assign defer = op_check_i ? pois1_i : (!spec_i && (p1_used || p2_used));
  assign imm   = !op_check_i && fault_i && (!spec_i || fault_imm_i);

  always_comb begin
    exc_d_o   = op_valid_i && (defer || imm);
    cause_d_o = CAUSE_NONE;
    idx_d_o   = '0;
    if (exc_d_o) begin
      if (defer) begin
        cause_d_o = CAUSE_DEFER;
        idx_d_o   = (op_check_i || p1_used) ? rs1_i : rs2_i;
      end else begin
        cause_d_o = CAUSE_IMM;
        idx_d_o   = rd_i;
      end
    end
  end

  assign wr_en_o   = op_valid_i && !op_check_i && we_i && (rd_i != '0) && !exc_d_o;
  assign wr_pois_o = spec_i && (fault_i || p1_used || p2_used);

  assert_trap_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_d_o |-> !wr_en_o);
  assert_check_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_check_i) |-> !wr_en_o);
endmodule

// File: rtl/dp_exc_reg.sv
module dp_exc_reg
  import defer_poison_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic          exc_d_i,
  input  exc_cause_e    cause_d_i,
  input  logic [AW-1:0] idx_d_i,
  output logic          exc_o,
  output logic [1:0]    cause_o,
  output logic [AW-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_o   <= 1'b0;
      cause_o <= CAUSE_NONE;
      idx_o   <= '0;
    end else begin
      exc_o   <= exc_d_i;
      cause_o <= exc_d_i ? cause_d_i : CAUSE_NONE;
      idx_o   <= exc_d_i ? idx_d_i : '0;
    end
  end

  assert_pulse_follows_op_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> $past(op_valid_i));
  assert_cause_coherent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_o) && (exc_o == (cause_o != 2'b00)));
endmodule

// File: rtl/defer_poison_rf.sv
module defer_poison_rf
  import defer_poison_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int XLEN  = 64,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  input  logic            op_check_i,
  input  logic            spec_i,
  input  logic            fault_i,
  input  logic            fault_imm_i,
  input  logic            src1_use_i,
  input  logic            src2_use_i,
  input  logic [AW-1:0]   rs1_i,
  input  logic [AW-1:0]   rs2_i,
  input  logic [AW-1:0]   rd_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata1_o,
  output logic            rpois1_o,
  output logic [XLEN-1:0] rdata2_o,
  output logic            rpois2_o,
  output logic            exc_o,
  output logic [1:0]      exc_cause_o,
  output logic [AW-1:0]   exc_idx_o
);
  logic          wr_en, wr_pois, exc_d;
  exc_cause_e    cause_d;
  logic [AW-1:0] idx_d;

  dp_regarray #(.NREGS(NREGS), .XLEN(XLEN)) u_regs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra1_i (rs1_i),
    .ra2_i (rs2_i),
    .rd1_o (rdata1_o),
    .rp1_o (rpois1_o),
    .rd2_o (rdata2_o),
    .rp2_o (rpois2_o),
    .we_i  (wr_en),
    .wa_i  (rd_i),
    .wd_i  (wdata_i),
    .wp_i  (wr_pois)
  );

  dp_ctrl #(.NREGS(NREGS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid_i),
    .op_check_i (op_check_i),
    .spec_i     (spec_i),
    .fault_i    (fault_i),
    .fault_imm_i(fault_imm_i),
    .src1_use_i (src1_use_i),
    .src2_use_i (src2_use_i),
    .rs1_i      (rs1_i),
    .rs2_i      (rs2_i),
    .rd_i       (rd_i),
    .we_i       (we_i),
    .pois1_i    (rpois1_o),
    .pois2_i    (rpois2_o),
    .wr_en_o    (wr_en),
    .wr_pois_o  (wr_pois),
    .exc_d_o    (exc_d),
    .cause_d_o  (cause_d),
    .idx_d_o    (idx_d)
  );

  dp_exc_reg #(.NREGS(NREGS)) u_exc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_valid_i(op_valid_i),
    .exc_d_i   (exc_d),
    .cause_d_i (cause_d),
    .idx_d_i   (idx_d),
    .exc_o     (exc_o),
    .cause_o   (exc_cause_o),
    .idx_o     (exc_idx_o)
  );

  assert_spec_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !op_check_i && spec_i && !fault_imm_i) |=> !exc_o);
  assert_check_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_check_i && !rpois1_o) |=> !exc_o);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !exc_o);
endmodule

// File: tb/defer_poison_rf_tb.sv
module defer_poison_rf_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 0, op_check_i = 0, spec_i = 0, fault_i = 0, fault_imm_i = 0;
  logic        src1_use_i = 0, src2_use_i = 0, we_i = 0;
  logic [4:0]  rs1_i = 0, rs2_i = 0, rd_i = 0;
  logic [63:0] wdata_i = 0;
  logic [63:0] rdata1_o, rdata2_o;
  logic        rpois1_o, rpois2_o, exc_o;
  logic [1:0]  exc_cause_o;
  logic [4:0]  exc_idx_o;

  int total = 0, bad = 0;
  logic       l_exc;
  logic [1:0] l_cause;
  logic [4:0] l_idx;

  always #10 clk_i = ~clk_i;

  defer_poison_rf dut_i (.*);

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, hold over one posedge, capture exc at next negedge
  task automatic op(input logic chk_op, input logic sp, input logic flt, input logic im,
                    input logic u1, input logic u2, input int a1, input int a2,
                    input int d, input logic w, input logic [63:0] v);
    @(negedge clk_i);
    op_valid_i = 1; op_check_i = chk_op; spec_i = sp; fault_i = flt; fault_imm_i = im;
    src1_use_i = u1; src2_use_i = u2; rs1_i = 5'(a1); rs2_i = 5'(a2); rd_i = 5'(d);
    we_i = w; wdata_i = v;
    @(negedge clk_i);
    l_exc = exc_o; l_cause = exc_cause_o; l_idx = exc_idx_o;
    op_valid_i = 0; we_i = 0; fault_i = 0; op_check_i = 0;
  endtask

  task automatic peek(input int a, output logic [63:0] d, output logic p);
    rs1_i = 5'(a); rs2_i = 5'(a); #1;
    d = rdata1_o; p = rpois1_o;
  endtask

  task automatic chk_reg(input string req, input int a, input logic [63:0] ed, input logic ep);
    logic [63:0] d; logic p;
    peek(a, d, p);
    chk(req, {7'b0, p, d}, {7'b0, ep, ed});
    chk(req, {7'b0, rpois2_o, rdata2_o}, {7'b0, ep, ed});
  endtask

  task automatic chk_exc(input string req, input logic e, input logic [1:0] c, input logic [4:0] i);
    chk(req, {64'b0, l_exc, l_cause, l_idx}, {64'b0, e, c, i});
  endtask

  task automatic t_reset;
    #1;
    chk("R1 exc", {71'b0, exc_o}, 72'b0);
    chk_reg("R1 r5", 5, 64'h0, 1'b0);
    chk_reg("R1 r31", 31, 64'h0, 1'b0);
  endtask

  task automatic t_r0;
    op(0,0,0,0,0,0,0,0,0,1,64'hDEAD);
    chk_reg("R2 r0 write ignored", 0, 64'h0, 1'b0);
    op(0,1,1,0,0,0,0,0,0,1,64'hBEEF);
    chk_reg("R2 r0 no poison", 0, 64'h0, 1'b0);
    chk_exc("R2 r0 spec fault quiet", 0, 2'b00, 5'd0);
  endtask

  task automatic t_clean;
    op(0,0,0,0,0,0,0,0,3,1,64'h1111_2222_3333_4444);
    chk_exc("R3 no exc", 0, 2'b00, 5'd0);
    chk_reg("R3 write", 3, 64'h1111_2222_3333_4444, 1'b0);
  endtask

  task automatic t_spec_fault;
    op(0,1,1,0,0,0,0,0,4,1,64'hAAAA);
    chk_exc("R4 no exc", 0, 2'b00, 5'd0);
    chk_reg("R4 poisoned", 4, 64'hAAAA, 1'b1);
  endtask

  task automatic t_chain;
    op(0,1,0,0,1,0,4,0,5,1,64'h55);
    chk_exc("R5 step1 quiet", 0, 2'b00, 5'd0);
    chk_reg("R5 step1 poison", 5, 64'h55, 1'b1);
    op(0,1,0,0,0,1,0,5,6,1,64'h66);
    chk_exc("R5 step2 quiet", 0, 2'b00, 5'd0);
    chk_reg("R5 step2 poison", 6, 64'h66, 1'b1);
    op(0,1,0,0,0,0,4,5,12,1,64'h12);
    chk_reg("R5 unused source no poison", 12, 64'h12, 1'b0);
  endtask

  task automatic t_clear;
    op(0,0,0,0,0,0,0,0,4,1,64'h4444);
    chk_reg("R3 clean write clears poison", 4, 64'h4444, 1'b0);
    op(0,1,1,0,0,0,0,0,7,1,64'h77);
    chk_reg("R4 r7 poisoned", 7, 64'h77, 1'b1);
    op(0,0,0,0,0,0,0,0,7,1,64'h78);
    op(0,0,0,0,1,0,7,0,13,1,64'h13);
    chk_exc("R3 overwritten poison never fires", 0, 2'b00, 5'd0);
    chk_reg("R3 consumer wrote", 13, 64'h13, 1'b0);
    op(0,0,0,0,0,0,6,5,14,1,64'h14);
    chk_exc("R5 unused poisoned sources quiet", 0, 2'b00, 5'd0);
  endtask

  task automatic t_defer;
    op(0,0,0,0,1,0,6,0,8,1,64'h88);
    chk_exc("R6 deferred on use", 1, 2'b01, 5'd6);
    chk_reg("R6 no write", 8, 64'h0, 1'b0);
    @(negedge clk_i);
    chk("R10 single pulse", {71'b0, exc_o}, 72'b0);
    op(0,0,0,0,1,1,3,5,8,1,64'h89);
    chk_exc("R6 port2 reported", 1, 2'b01, 5'd5);
  endtask

  task automatic t_both;
    op(0,0,0,0,1,1,6,5,9,1,64'h99);
    chk_exc("R7 port1 wins", 1, 2'b01, 5'd6);
    op(0,0,0,0,1,1,5,6,9,1,64'h99);
    chk_exc("R7 port1 wins swapped", 1, 2'b01, 5'd5);
  endtask

  task automatic t_check;
    op(1,0,0,0,0,0,5,0,9,1,64'h9);
    chk_exc("R8 check poisoned", 1, 2'b01, 5'd5);
    chk_reg("R8 check no write", 9, 64'h0, 1'b0);
    op(1,0,0,0,0,0,3,6,9,1,64'h9);
    chk_exc("R8 check clean", 0, 2'b00, 5'd0);
  endtask

  task automatic t_imm;
    op(0,0,1,0,0,0,0,0,10,1,64'hA0);
    chk_exc("R9 nonspec fault", 1, 2'b10, 5'd10);
    chk_reg("R9 no write", 10, 64'h0, 1'b0);
    op(0,1,1,1,0,0,0,0,11,1,64'hB0);
    chk_exc("R9 spec immediate", 1, 2'b10, 5'd11);
    chk_reg("R9 spec imm no write", 11, 64'h0, 1'b0);
    op(0,0,1,0,1,0,6,0,11,1,64'hB1);
    chk_exc("R9 deferred priority", 1, 2'b01, 5'd6);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_r0();
    t_clean();
    t_spec_fault();
    t_chain();
    t_clear();
    t_defer();
    t_both();
    t_check();
    t_imm();
    @(negedge clk_i);
    chk("R10 idle low", {71'b0, exc_o}, 72'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule